// File: doc/BRIEF.md
# LPC Host Byte-Cycle Splitter

This block is the host end of a Low Pin Count bus bridge. An upstream agent gives it one memory or I/O request at a time. Each request carries a base address, a read/write flag, up to four byte enables and, for writes, a 32-bit data word. The block breaks the request into single-byte LPC cycles, one per enabled byte, and issues them in rising lane order. It drives the 4-bit LAD bus and the active-low frame strobe, then waits through the turnaround and sync phases for the peripheral's answer.

Read bytes are packed back into their lanes of the upstream data word. One completion pulse marks the end of the whole request. When no peripheral claims a cycle, the block behaves like an old pulled-up bus: the read lane comes back as 0xFF, and a write is dropped with no error. The request still completes normally in both cases.

Top module: `lpc_xfer_splitter`

## Requirements
- R1: Each set bit of `req_be` produces exactly one LPC cycle, and the cycles run in ascending lane order. A request with `req_be` = 0 completes with no LPC cycle, and no frame strobe follows the completion pulse.
- R2: The cycle for lane k carries the address `req_addr + k`. Memory cycles send 8 address nibbles and I/O cycles send the low 16 bits as 4 nibbles, most significant nibble first.
- R3: A cycle opens with `lframe_n` low for exactly one clock while LAD carries 0000. The next clock carries the type nibble: I/O read 0000, I/O write 0010, memory read 0100, memory write 0110.
- R4: A write cycle sends byte `req_wdata[8k+7:8k]` as two nibbles, low nibble first. After the data (or after the address for a read), the host drives 1111 for one clock and then releases LAD (`lad_oe` = 0) for one clock.
- R5: After a sync nibble of 0000 on a read, the next two LAD nibbles (low first) form the lane's byte in `rdata`. Lanes that are not enabled, and every lane of a write, read back as 0.
- R6: The long-wait sync 0110 may repeat without limit. The short-wait sync 0101 is allowed fewer than SHORT_WAIT_MAX (default 8) times in one cycle. The SHORT_WAIT_MAX-th short-wait nibble ends the cycle as unanswered.
- R7: Any sync nibble other than 0000, 0101, 0110 or 1010 counts as no answer. The NO_SYNC_MAX-th such clock (default 3) ends the cycle as unanswered. Fewer such clocks followed by 0000 still complete the cycle normally.
- R8: An unanswered cycle, or one answered with the error sync 1010, returns 0xFF in its read lane. A write under the same conditions is discarded, and the request still completes with `done`.
- R9: `done` pulses for one clock only after every enabled lane has finished, and `req_ready` then returns high. `req_ready` is high only while idle, and `req_valid` is ignored while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request strobe |
| req_ready | output | 1 | Block idle, request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 32 | Base byte address of lane 0 |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Gathered read data, valid with done |
| lframe_n | output | 1 | Active-low cycle frame strobe |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | Host drives LAD when high |
| lad_in | input | 4 | LAD value seen on the bus |

## Verification
A lane mask that is corrupted inside the block shows up at the ports within one cycle. An address nibble arrives with the wrong lane offset, an extra frame strobe appears, or one is missing before `done`. A nibble counter that is off by one shifts the type, address or data nibbles by a clock, and this is visible in the very cycle affected. A sync-phase counter with the wrong limit shows up only in a boundary case. It either turns a still-legal wait into 0xFF or lets a dead cycle complete with real data. The bench therefore places wait and invalid-nibble counts just below and exactly at each limit.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [3:0] {
    E_IDLE, E_START, E_CT, E_ADDR, E_WDAT, E_TAR, E_SYNC, E_RDAT, E_TAR2
  } eng_state_t;

  typedef enum logic [1:0] {T_IDLE, T_LAUNCH, T_WAIT} top_state_t;

  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;
endpackage

// File: rtl/lpc_lane_pick.sv
module lpc_lane_pick #(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic             any,
  output logic [LW-1:0]    idx
);
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/lpc_byte_cycle.sv
module lpc_byte_cycle
  import lpc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int SHORT_WAIT_MAX = 8,
  parameter int NO_SYNC_MAX    = 3,
  localparam int MEM_NIBS = ADDR_W / 4,
  localparam int IO_NIBS  = 4,
  localparam int CNTW     = $clog2(MEM_NIBS),
  localparam int SWW      = $clog2(SHORT_WAIT_MAX + 1),
  localparam int NSW      = $clog2(NO_SYNC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_io,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  input  logic [3:0]        lad_in,
  output logic              lframe_n,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              done,
  output logic [7:0]        rbyte
);
  localparam logic [SWW-1:0] SW_LAST = SWW'(SHORT_WAIT_MAX - 1);
  localparam logic [NSW-1:0] NS_LAST = NSW'(NO_SYNC_MAX - 1);

  eng_state_t        st_q, st_d;
  logic [CNTW-1:0]   cnt_q, cnt_d, nlast, nib_idx;
  logic [SWW-1:0]    sw_q, sw_d;
  logic [NSW-1:0]    inv_q, inv_d;
  logic [7:0]        byte_q, byte_d, wb_q;
  logic              done_q, done_d, io_q, wr_q, ld_req;
  logic [ADDR_W-1:0] addr_q;

  assign nlast   = io_q ? CNTW'(IO_NIBS - 1) : CNTW'(MEM_NIBS - 1);
  assign nib_idx = nlast - cnt_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sw_d = sw_q; inv_d = inv_q;
    byte_d = byte_q; done_d = 1'b0; ld_req = 1'b0;
    case (st_q)
      E_IDLE:  if (start) begin st_d = E_START; ld_req = 1'b1; byte_d = 8'hFF; end
      E_START: st_d = E_CT;
      E_CT:    begin st_d = E_ADDR; cnt_d = '0; end
      E_ADDR:  if (cnt_q == nlast) begin
                 cnt_d = '0;
                 st_d  = wr_q ? E_WDAT : E_TAR;
               end else cnt_d = cnt_q + 1'b1;
      E_WDAT:  if (cnt_q[0]) begin cnt_d = '0; st_d = E_TAR; end
               else cnt_d = cnt_q + 1'b1;
      E_TAR:   if (cnt_q[0]) begin
                 cnt_d = '0; sw_d = '0; inv_d = '0; st_d = E_SYNC;
               end else cnt_d = cnt_q + 1'b1;
      E_SYNC:  case (lad_in)
                 SYNC_READY: begin cnt_d = '0; st_d = wr_q ? E_TAR2 : E_RDAT; end
                 SYNC_ERR:   st_d = E_TAR2;
                 SYNC_LONG:  st_d = E_SYNC;
                 SYNC_SHORT: if (sw_q == SW_LAST) begin st_d = E_IDLE; done_d = 1'b1; end
                             else sw_d = sw_q + 1'b1;
                 default:    if (inv_q == NS_LAST) begin st_d = E_IDLE; done_d = 1'b1; end
                             else inv_d = inv_q + 1'b1;
               endcase
      E_RDAT:  if (!cnt_q[0]) begin byte_d[3:0] = lad_in; cnt_d = cnt_q + 1'b1; end
               else begin byte_d[7:4] = lad_in; cnt_d = '0; st_d = E_TAR2; end
      E_TAR2:  if (cnt_q[0]) begin cnt_d = '0; st_d = E_IDLE; done_d = 1'b1; end
               else cnt_d = cnt_q + 1'b1;
      default: st_d = E_IDLE;
    endcase
  end

  always_comb begin
    lad_out = 4'hF;
    lad_oe  = 1'b0;
    case (st_q)
      E_START: begin lad_out = 4'h0; lad_oe = 1'b1; end
      E_CT:    begin lad_out = {1'b0, ~io_q, wr_q, 1'b0}; lad_oe = 1'b1; end
      E_ADDR:  begin lad_out = addr_q[{nib_idx, 2'b00} +: 4]; lad_oe = 1'b1; end
      E_WDAT:  begin lad_out = cnt_q[0] ? wb_q[7:4] : wb_q[3:0]; lad_oe = 1'b1; end
      E_TAR:   lad_oe = ~cnt_q[0];
      default: lad_oe = 1'b0;
    endcase
  end

  assign lframe_n = (st_q != E_START);
  assign done     = done_q;
  assign rbyte    = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; cnt_q <= '0; sw_q <= '0; inv_q <= '0;
      byte_q <= 8'hFF; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sw_q <= sw_d; inv_q <= inv_d;
      byte_q <= byte_d; done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q <= 1'b0; wr_q <= 1'b0; addr_q <= '0; wb_q <= '0;
    end else if (ld_req) begin
      io_q <= is_io; wr_q <= is_wr; addr_q <= addr; wb_q <= wbyte;
    end
  end

  // R3
  frame_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n);
  // R9
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> st_q == E_IDLE);
  // R4
  release_after_tar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_TAR && lad_oe) |=> !lad_oe);
  // R9
  eng_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/lpc_xfer_splitter.sv
module lpc_xfer_splitter
  import lpc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LANES          = 4,
  parameter int SHORT_WAIT_MAX = 8,
  parameter int NO_SYNC_MAX    = 3,
  localparam int LW = $clog2(LANES),
  localparam int DW = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              lframe_n,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [3:0]        lad_in
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  top_state_t        st_q, st_d;
  logic [LANES-1:0]  mask_q, mask_d;
  logic [LW-1:0]     lane_q, lane_d, pick_idx;
  logic              pick_any, wr_q, io_q, take;
  logic [ADDR_W-1:0] base_q;
  logic [DW-1:0]     wd_q, rd_q, rd_d;
  logic              eng_start, eng_done;
  logic [7:0]        eng_byte;

  lpc_lane_pick #(.LANES(LANES)) u_pick (
    .mask(mask_q), .any(pick_any), .idx(pick_idx)
  );

  assign take      = (st_q == T_IDLE) && req_valid;
  assign eng_start = (st_q == T_LAUNCH) && pick_any;
  assign done      = (st_q == T_LAUNCH) && !pick_any;
  assign req_ready = (st_q == T_IDLE);
  assign rdata     = rd_q;

  always_comb begin
    st_d = st_q; mask_d = mask_q; lane_d = lane_q; rd_d = rd_q;
    case (st_q)
      T_IDLE:   if (take) begin
                  st_d = T_LAUNCH; mask_d = req_be; rd_d = '0;
                end
      T_LAUNCH: if (pick_any) begin
                  st_d = T_WAIT; lane_d = pick_idx;
                  mask_d[pick_idx] = 1'b0;
                end else st_d = T_IDLE;
      T_WAIT:   if (eng_done) begin
                  st_d = T_LAUNCH;
                  if (!wr_q) rd_d[lane_q*8 +: 8] = eng_byte;
                end
      default:  st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= T_IDLE; mask_q <= '0; lane_q <= '0; rd_q <= '0;
    end else begin
      st_q <= st_d; mask_q <= mask_d; lane_q <= lane_d; rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q <= 1'b0; io_q <= 1'b0; base_q <= '0; wd_q <= '0;
    end else if (take) begin
      wr_q <= req_write; io_q <= req_io; base_q <= req_addr; wd_q <= req_wdata;
    end
  end

  lpc_byte_cycle #(
    .ADDR_W(ADDR_W), .SHORT_WAIT_MAX(SHORT_WAIT_MAX), .NO_SYNC_MAX(NO_SYNC_MAX)
  ) u_cycle (
    .clk(clk), .rst_n(rst_n_s), .start(eng_start),
    .is_io(io_q), .is_wr(wr_q),
    .addr(base_q + {{(ADDR_W-LW){1'b0}}, pick_idx}),
    .wbyte(wd_q[pick_idx*8 +: 8]),
    .lad_in(lad_in), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .done(eng_done), .rbyte(eng_byte)
  );

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> req_ready);
  // R1
  frame_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lframe_n |-> !req_ready);
endmodule

// File: tb/lpc_xfer_splitter_test.sv
module lpc_xfer_splitter_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int NS = 3;
  localparam int K_LONG = 0, K_SHORT = 1, K_INV = 2, K_ERR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0, lad_in = 4'hF;
  logic req_ready, done, lframe_n, lad_oe;
  logic [31:0] rdata;
  logic [3:0]  lad_out;

  int n_cmp = 0, n_bad = 0;
  logic        exp_wr, exp_io;
  logic [31:0] exp_addr, exp_wd, exp_rd;
  int kind [4];
  int kcnt [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_xfer_splitter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .lframe_n(lframe_n),
    .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] nib);
    lad_in = nib;
    @(negedge clk);
  endtask

  task automatic serve_cycle(input int lane);
    int w;
    logic [31:0] a, a_exp;
    logic [3:0] lo, hi, ct;
    logic [7:0] d;
    logic acc;
    w = 0;
    while (lframe_n !== 1'b0 && w < 300) begin @(negedge clk); w++; end
    chk("R1 frame strobe seen", {31'd0, lframe_n}, 32'd0);
    chk("R9 busy during cycle", {31'd0, req_ready}, 32'd0);
    chk("R3 start nibble", {27'd0, lad_oe, lad_out}, 32'h10);
    req_valid = 1'b1; req_addr = ~exp_addr; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    ct = lad_out;
    chk("R3 type nibble", {27'd0, lframe_n, ct}, {27'd0, 1'b1, 1'b0, ~exp_io, exp_wr, 1'b0});
    a = '0;
    for (int i = 0; i < (exp_io ? 4 : 8); i++) begin
      @(negedge clk);
      a = {a[27:0], lad_out};
    end
    a_exp = exp_addr + 32'(lane);
    if (exp_io) a_exp[31:16] = '0;
    chk("R2 cycle address", a, a_exp);
    if (exp_wr) begin
      @(negedge clk); lo = lad_out;
      @(negedge clk); hi = lad_out;
      chk("R4 write byte", {24'd0, hi, lo}, {24'd0, exp_wd[8*lane +: 8]});
    end
    @(negedge clk);
    chk("R4 turnaround drive", {27'd0, lad_oe, lad_out}, 32'h1F);
    @(negedge clk);
    chk("R4 turnaround release", {31'd0, lad_oe}, 32'd0);
    @(negedge clk);
    acc = 1'b0;
    case (kind[lane])
      K_LONG:  begin repeat (kcnt[lane]) drive(4'h6); drive(4'h0); acc = 1'b1; end
      K_SHORT: if (kcnt[lane] < SW) begin
                 repeat (kcnt[lane]) drive(4'h5); drive(4'h0); acc = 1'b1;
               end else repeat (SW) drive(4'h5);
      K_INV:   if (kcnt[lane] < NS) begin
                 repeat (kcnt[lane]) drive(4'hF); drive(4'h0); acc = 1'b1;
               end else repeat (NS) drive(4'hF);
      default: drive(4'hA);
    endcase
    d = a_exp[7:0] ^ 8'h3C;
    if (acc && !exp_wr) begin drive(d[3:0]); drive(d[7:4]); end
    lad_in = 4'hF;
    if (!exp_wr) exp_rd[8*lane +: 8] = acc ? d : 8'hFF;
  endtask

  task automatic do_req(input logic wr, input logic io, input logic [31:0] addr,
                        input logic [3:0] be, input logic [31:0] wd);
    int w;
    exp_wr = wr; exp_io = io; exp_addr = addr; exp_wd = wd; exp_rd = '0;
    req_valid = 1'b1; req_write = wr; req_io = io;
    req_addr = addr; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int ln = 0; ln < 4; ln++) if (be[ln]) serve_cycle(ln);
    w = 0;
    while (done !== 1'b1 && w < 300) begin
      chk("R1 no extra frame", {31'd0, lframe_n}, 32'd1);
      @(negedge clk); w++;
    end
    chk("R9 done seen", {31'd0, done}, 32'd1);
    chk("R5 R8 gathered rdata", rdata, exp_rd);
    @(negedge clk);
    chk("R9 single done pulse", {30'd0, done, req_ready}, 32'd1);
    chk("R1 no frame after done", {31'd0, lframe_n}, 32'd1);
  endtask

  task automatic set_all(input int k, input int n);
    for (int i = 0; i < 4; i++) begin kind[i] = k; kcnt[i] = n; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    set_all(K_LONG, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset idle", {28'd0, req_ready, lframe_n, lad_oe, done}, 32'hC);

    // R1 R2 R5: I/O reads over every enable mask, varied long waits
    for (int be = 0; be < 16; be++) begin
      for (int i = 0; i < 4; i++) begin kind[i] = K_LONG; kcnt[i] = (be + i) % 3; end
      do_req(1'b0, 1'b1, 32'h0000_FFFD + 32'(be), 4'(be), '0);
    end
    // R4 R8: memory writes over every mask, all response kinds
    for (int be = 0; be < 16; be++) begin
      for (int i = 0; i < 4; i++) begin kind[i] = (be + i) % 4; kcnt[i] = i; end
      do_req(1'b1, 1'b0, 32'h8000_0000 + 32'(be) * 16, 4'(be), 32'h1234_5678 ^ {8{4'(be)}});
    end
    // R6 short-wait boundary
    set_all(K_SHORT, SW - 1); do_req(1'b0, 1'b0, 32'hFEDC_BA90, 4'b0001, '0);
    set_all(K_SHORT, SW);     do_req(1'b0, 1'b0, 32'hFEDC_BA90, 4'b0001, '0);
    // R6 long wait unbounded
    set_all(K_LONG, 20);      do_req(1'b0, 1'b0, 32'h0001_0002, 4'b0100, '0);
    // R7 invalid-nibble boundary
    set_all(K_INV, NS - 1);   do_req(1'b0, 1'b0, 32'h00C0_0010, 4'b1000, '0);
    set_all(K_INV, NS);       do_req(1'b0, 1'b0, 32'h00C0_0010, 4'b1000, '0);
    // R8 error sync and absent I/O write
    set_all(K_ERR, 0);        do_req(1'b0, 1'b1, 32'h0000_0060, 4'b0010, '0);
    set_all(K_INV, NS);       do_req(1'b1, 1'b1, 32'h0000_0080, 4'b1111, 32'hA5A5_5A5A);
    // R5 R8: mixed kinds within one memory read
    kind[0] = K_SHORT; kcnt[0] = SW;
    kind[1] = K_LONG;  kcnt[1] = 1;
    kind[2] = K_ERR;   kcnt[2] = 0;
    kind[3] = K_INV;   kcnt[3] = 1;
    do_req(1'b0, 1'b0, 32'h3FFF_FFFE, 4'b1111, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule